// File: doc/BRIEF.md
# Stable-Input Fault Credit Weight Learner

This block learns per-input bias weights for a weighted pseudo-random two-pattern test generator. For each applied test it receives the launch vector, the capture vector and the number of path-delay faults that the test detected. Every circuit input that kept the same value across the pair is credited with that number, in a stable-zero tally or in a stable-one tally. Inputs that toggled receive nothing.

Credit is withheld during a warm-up period of basis patterns, so that the flood of easy faults found early does not dominate the statistics. When the basis-pattern count reaches a programmable limit, collection ends. The block then walks the inputs one at a time through a restoring divider and produces, for each input, the fraction of its credit earned while stable at one. That fraction is the probability with which the generator should drive a one on that input. A clear command starts a new learning run.

Top module: `fault_weight_unit`

## Requirements
- R1: After reset, `done` is 0 and every weight field reads 0x8000.
- R2: A counted test credits `fault_cnt` to the stable-one tally of each input whose launch and capture bits are both 1, and to the stable-zero tally of each input whose bits are both 0.
- R3: An input whose launch bit differs from its capture bit gets no credit in either tally for that test.
- R4: The basis count is the number of `basis_tick` pulses since reset or clear. A test is counted only while that count is at least 100; tests applied earlier leave both tallies unchanged.
- R5: Once the basis count equals `stop_limit`, further ticks and tests are ignored and do not change any weight, before or after `done`.
- R6: Input i's weight, at `weight_out[16*i +: 16]`, is floor(S1 * 65536 / (S0 + S1)), with 0xFFFF when S0 is 0 and S1 is not 0.
- R7: An input with S0 + S1 equal to 0 gets the weight 0x8000.
- R8: Each tally saturates at 65535 and does not wrap.
- R9: `done` rises within N_IN*19+4 cycles after the basis count reaches `stop_limit`, once all weights are written, and then stays high until a clear.
- R10: `clr` lowers `done` at the next cycle and zeroes both tallies of every input and the basis count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Start a new learning run |
| basis_tick | input | 1 | One basis pattern applied |
| test_valid | input | 1 | A test result is present this cycle |
| launch_vec | input | N_IN | First vector of the pair |
| capture_vec | input | N_IN | Second vector of the pair |
| fault_cnt | input | FC_W | Faults detected by this test |
| stop_limit | input | BASIS_W | Basis count that ends collection |
| weight_out | output | N_IN*W_FRAC | Packed one-probability fractions |
| done | output | 1 | All weights computed |

## Verification
A counted test changes only internal tallies, so its effect is seen at the weight outputs after the division pass; the bench waits for `done` and samples every weight field at the falling edge after it, counting cycles from the edge on which the final tick lands to confirm the R9 bound. The division pass takes one start cycle, sixteen iteration cycles and one write cycle per input. Clear is checked one cycle after it is applied. Ignored stimuli (warm-up tests, tests after the limit, tests after `done`) are checked through the final weights and by reading the weights again after extra stimulus.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT   = 2'd0,
    ST_DIV_START = 2'd1,
    ST_DIV_WAIT  = 2'd2,
    ST_DONE      = 2'd3
  } wfs_state_e;
endpackage

// File: rtl/wfs_counter_bank.sv
module wfs_counter_bank #(
  parameter int N_IN  = 8,
  parameter int CNT_W = 16,
  parameter int FC_W  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic [N_IN-1:0]  launch,
  input  logic [N_IN-1:0]  capture,
  input  logic [FC_W-1:0]  fault_cnt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_s0,
  output logic [CNT_W-1:0] rd_s1
);
  logic [CNT_W-1:0] s0_arr [N_IN];
  logic [CNT_W-1:0] s1_arr [N_IN];

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                              input logic [FC_W-1:0] b);
    logic [CNT_W:0] sum;
    sum = {1'b0, a} + (CNT_W+1)'(b);
    return sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  endfunction

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    logic [CNT_W-1:0] c0_q, c1_q;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        c0_q <= '0;
        c1_q <= '0;
      end else if (cnt_en && (launch[g] == capture[g])) begin
        if (capture[g]) c1_q <= sat_add(c1_q, fault_cnt);
        else            c0_q <= sat_add(c0_q, fault_cnt);
      end
    end
    assign s0_arr[g] = c0_q;
    assign s1_arr[g] = c1_q;
  end

  assign rd_s0 = s0_arr[rd_idx];
  assign rd_s1 = s1_arr[rd_idx];
endmodule

// File: rtl/wfs_ratio_div.sv
module wfs_ratio_div #(
  parameter int NUM_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              start,
  input  logic [NUM_W-1:0]  num,
  input  logic [NUM_W:0]    den,
  output logic              busy,
  output logic              res_valid,
  output logic [FRAC_W-1:0] quot
);
  localparam int R_W    = NUM_W + 2;
  localparam int STEP_W = $clog2(FRAC_W + 1);

  logic [R_W-1:0]    rem_q;
  logic [NUM_W:0]    den_q;
  logic [STEP_W-1:0] steps_q;
  logic [R_W-1:0]    shifted;
  logic              trial_ok;

  assign shifted  = rem_q << 1;
  assign trial_ok = shifted >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy      <= 1'b0;
      res_valid <= 1'b0;
      quot      <= '0;
      rem_q     <= '0;
      den_q     <= '0;
      steps_q   <= '0;
    end else begin
      res_valid <= 1'b0;
      if (start && !busy) begin
        if (den == '0) begin
          quot      <= {1'b1, {(FRAC_W-1){1'b0}}};
          res_valid <= 1'b1;
        end else begin
          rem_q   <= R_W'(num);
          den_q   <= den;
          quot    <= '0;
          steps_q <= STEP_W'(FRAC_W);
          busy    <= 1'b1;
        end
      end else if (busy) begin
        rem_q   <= trial_ok ? (shifted - R_W'(den_q)) : shifted;
        quot    <= {quot[FRAC_W-2:0], trial_ok};
        steps_q <= steps_q - 1'b1;
        if (steps_q == STEP_W'(1)) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fault_weight_unit.sv
module fault_weight_unit
  import wfs_pkg::*;
#(
  parameter int N_IN    = 8,
  parameter int CNT_W   = 16,
  parameter int FC_W    = 8,
  parameter int W_FRAC  = 16,
  parameter int BASIS_W = 32,
  parameter int WARMUP  = 100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     basis_tick,
  input  logic                     test_valid,
  input  logic [N_IN-1:0]          launch_vec,
  input  logic [N_IN-1:0]          capture_vec,
  input  logic [FC_W-1:0]          fault_cnt,
  input  logic [BASIS_W-1:0]       stop_limit,
  output logic [N_IN*W_FRAC-1:0]   weight_out,
  output logic                     done
);
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam logic [W_FRAC-1:0] HALF = {1'b1, {(W_FRAC-1){1'b0}}};

  wfs_state_e         state;
  logic [BASIS_W-1:0] basis_cnt;
  logic [IDX_W-1:0]   idx;
  logic               cnt_en;
  logic [CNT_W-1:0]   rd_s0, rd_s1;
  logic [CNT_W:0]     den;
  logic               div_busy, div_valid;
  logic [W_FRAC-1:0]  div_quot;

  assign cnt_en = (state == ST_COLLECT) && test_valid &&
                  (basis_cnt >= BASIS_W'(WARMUP)) && (basis_cnt < stop_limit);
  assign den    = {1'b0, rd_s0} + {1'b0, rd_s1};

  wfs_counter_bank #(.N_IN(N_IN), .CNT_W(CNT_W), .FC_W(FC_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .clr(clr), .cnt_en(cnt_en),
    .launch(launch_vec), .capture(capture_vec), .fault_cnt(fault_cnt),
    .rd_idx(idx), .rd_s0(rd_s0), .rd_s1(rd_s1)
  );

  wfs_ratio_div #(.NUM_W(CNT_W), .FRAC_W(W_FRAC)) u_div (
    .clk(clk), .rst(rst), .flush(clr), .start(state == ST_DIV_START),
    .num(rd_s1), .den(den), .busy(div_busy), .res_valid(div_valid), .quot(div_quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_COLLECT;
      basis_cnt  <= '0;
      idx        <= '0;
      done       <= 1'b0;
      weight_out <= {N_IN{HALF}};
    end else if (clr) begin
      state     <= ST_COLLECT;
      basis_cnt <= '0;
      idx       <= '0;
      done      <= 1'b0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (basis_tick && (basis_cnt < stop_limit)) basis_cnt <= basis_cnt + 1'b1;
          if (basis_cnt >= stop_limit) begin
            state <= ST_DIV_START;
            idx   <= '0;
          end
        end
        ST_DIV_START: state <= ST_DIV_WAIT;
        ST_DIV_WAIT: begin
          if (div_valid) begin
            weight_out[idx*W_FRAC +: W_FRAC] <= div_quot;
            if (idx == IDX_W'(N_IN-1)) begin
              state <= ST_DONE;
              done  <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_DIV_START;
            end
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/wfs_checker.sv
module wfs_checker
  import wfs_pkg::*;
#(
  parameter int N_IN    = 8,
  parameter int W_FRAC  = 16,
  parameter int BASIS_W = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clr,
  input logic                   done,
  input logic [BASIS_W-1:0]     basis_cnt,
  input wfs_state_e             state,
  input logic                   div_busy,
  input logic [N_IN*W_FRAC-1:0] weight_out
);
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> done);

  // R10
  clr_done_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!done && basis_cnt == '0));

  // R5
  basis_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_COLLECT && !clr) |=> $stable(basis_cnt));

  // R6
  weight_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    div_busy |=> $stable(weight_out));

  // R9
  done_state_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (state == ST_DONE));
endmodule

bind fault_weight_unit wfs_checker #(.N_IN(N_IN), .W_FRAC(W_FRAC), .BASIS_W(BASIS_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .done(done), .basis_cnt(basis_cnt),
  .state(state), .div_busy(div_busy), .weight_out(weight_out)
);

// File: tb/fault_weight_unit_tb.sv
module fault_weight_unit_tb;
  localparam int N_IN = 8;
  localparam int WF   = 16;
  localparam longint CMAX = 65535;

  logic clk = 1'b0;
  logic rst, clr, basis_tick, test_valid;
  logic [N_IN-1:0] launch_vec, capture_vec;
  logic [7:0] fault_cnt;
  logic [31:0] stop_limit;
  logic [N_IN*WF-1:0] weight_out;
  logic done;

  int checks = 0;
  int errors = 0;
  longint m0 [N_IN];
  longint m1 [N_IN];
  longint ticks;
  longint limit;

  always #10 clk = ~clk;

  fault_weight_unit u_dut (
    .clk(clk), .rst(rst), .clr(clr), .basis_tick(basis_tick), .test_valid(test_valid),
    .launch_vec(launch_vec), .capture_vec(capture_vec), .fault_cnt(fault_cnt),
    .stop_limit(stop_limit), .weight_out(weight_out), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint expw(input longint s0, input longint s1);
    longint q;
    if (s0 + s1 == 0) return 32768;
    q = (s1 * 65536) / (s0 + s1);
    if (q > 65535) q = 65535;
    return q;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N_IN; i++) begin m0[i] = 0; m1[i] = 0; end
    ticks = 0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      basis_tick = 1'b1;
      @(negedge clk);
      basis_tick = 1'b0;
      if (ticks < limit) ticks++;
    end
  endtask

  task automatic apply(input logic [N_IN-1:0] l, input logic [N_IN-1:0] c, input int f);
    launch_vec = l; capture_vec = c; fault_cnt = 8'(f); test_valid = 1'b1;
    @(negedge clk);
    test_valid = 1'b0;
    if (ticks >= 100 && ticks < limit) begin
      for (int i = 0; i < N_IN; i++) begin
        if (l[i] == c[i]) begin
          if (c[i]) m1[i] = (m1[i] + f > CMAX) ? CMAX : m1[i] + f;
          else      m0[i] = (m0[i] + f > CMAX) ? CMAX : m0[i] + f;
        end
      end
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk(done && n <= N_IN*19+4, tag, n, N_IN*19+4);
  endtask

  task automatic check_weights(input string tag);
    for (int i = 0; i < N_IN; i++) begin
      longint e = expw(m0[i], m1[i]);
      chk(weight_out[i*WF +: WF] == 16'(e), $sformatf("%s w%0d", tag, i),
          longint'(weight_out[i*WF +: WF]), e);
    end
  endtask

  task automatic t_reset();
    // R1: idle state after reset
    chk(done == 1'b0, "R1 done", done, 0);
    for (int i = 0; i < N_IN; i++)
      chk(weight_out[i*WF +: WF] == 16'h8000, "R1 weight", weight_out[i*WF +: WF], 16'h8000);
  endtask

  task automatic t_run1();
    // R4: tests during warm-up are not credited
    apply(8'h0F, 8'h0F, 50);
    tick(99);
    apply(8'hF0, 8'hF0, 200);
    tick(1);
    // R2 / R3: stable credit, toggling inputs (bit7 always) get none
    apply(8'h40, 8'hC0, 10);
    apply(8'h4F, 8'hCF, 30);
    apply(8'h55, 8'hD5, 7);
    apply(8'hC3, 8'h43, 255);
    apply(8'h48, 8'hC0, 100);
    apply(8'h70, 8'hF0, 0);
    tick(50);
    // R5: test after the limit is ignored
    apply(8'h00, 8'h00, 222);
    wait_done("R9 done latency run1");
    @(negedge clk);
    check_weights("R6 R7 R3 R2 R4 run1");
    // R7: input 7 never stable -> half
    chk(weight_out[7*WF +: WF] == 16'h8000, "R7 toggling input", weight_out[7*WF +: WF], 16'h8000);
    // R6: input 6 only stable at one -> all ones
    chk(weight_out[6*WF +: WF] == 16'hFFFF, "R6 all-one input", weight_out[6*WF +: WF], 16'hFFFF);
    // R5: stimulus after done changes nothing
    tick(5);
    apply(8'h00, 8'h00, 99);
    apply(8'hFF, 8'hFF, 99);
    idle(3);
    check_weights("R5 after done");
    chk(done == 1'b1, "R9 done held", done, 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model_clear();
    // R10: done drops one cycle after clear
    chk(done == 1'b0, "R10 done low", done, 0);
  endtask

  task automatic t_run2();
    tick(100);
    // R8: tallies saturate
    for (int k = 0; k < 300; k++) apply(8'h01, 8'h01, 255);
    apply(8'h02, 8'h02, 255);
    tick(20);
    wait_done("R9 done latency run2");
    @(negedge clk);
    check_weights("R8 R10 run2");
    // R10: input 6 credited only in run1; cleared tallies leave its S1 at 0
    chk(weight_out[6*WF +: WF] == 16'h0000, "R10 cleared tally", weight_out[6*WF +: WF], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; clr = 1'b0; basis_tick = 1'b0; test_valid = 1'b0;
    launch_vec = '0; capture_vec = '0; fault_cnt = '0;
    stop_limit = 32'd150; limit = 150;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_run1();
    stop_limit = 32'd120; limit = 120;
    t_clear();
    t_run2();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule